// File: doc/BRIEF.md
# Tamper Security State Controller

This block holds the security condition of a tamper monitor. Ten digital event lines come in from sensors outside the block: voltage, clock, temperature, secure-controller alarm, external boot, external A, external B, wire-mesh, timer overflow and monotonic-counter overflow. Each event line has a sticky detect flag and an enable bit. An event whose enable bit is set drops the unit into the failure condition. While the unit is in that condition, the freeze output holds the time counter so that it keeps the moment of the violation.

Two flags record the condition. The non-valid flag is set by a battery power-on reset. The violation flag is set by an enabled event. When neither flag is set, the unit is valid. Software recovers the unit through a fixed sequence. First a system reset, taken while the violation flag is set, adds non-valid to failure. Then software zeroes the enables, clears the detect flags, clears the violation flag and finally clears the non-valid flag. Lock bits guard the enable register. The soft lock is released by the system reset. The hard locks are released only by the battery reset.

Writes go in through one port with a 2-bit select: 0 writes the tamper enables, 1 sets lock bits in the control word, 2 is the write-1-to-clear status word, and 3 writes the interrupt enable. Each write takes effect at the clock edge on which `wr_en` is sampled high.

Top module: `tamper_sec_ctrl`

## Requirements
- R1: After battery reset (`batt_rst_n` low), `status_o` = 0x0000_0002 (only non-valid, bit 1, set). `tamper_en_o`, `ctrl_o`, `irq_en_o`, `viol_irq_o` and `freeze_o` are all 0.
- R2: Event line i sets a sticky detect flag at the edge where it is sampled high. For i = 0..7 (voltage, clock, temperature, secure alarm, external boot, external A, external B, wire-mesh) the flag is status bit 16+i. Timer overflow (i = 8) is status bit 2 and monotonic overflow (i = 9) is status bit 3. The flag clears only when a 1 is written to its bit through select 2.
- R3: An event whose enable bit (`tamper_en_o[i]`) is set sets the violation flag (status bit 0) and `freeze_o` at the same edge. An event whose enable bit is clear sets only its detect flag.
- R4: A write to the enables (select 0) is ignored while the soft lock (control bit 29) or the hard lock (control bit 30) is set, or while the unit is in failure without non-valid. Such a write sets the write-error flag (status bit 7). Writing 1 to bit 7 through select 2 clears that flag.
- R5: A lock bit is set by writing 1 to it through select 1; writing 0 has no effect. A system reset clears bit 29. Bits 30 and 16 clear only on battery reset.
- R6: A system reset taken while the violation flag is set makes non-valid set, unless the failure hard lock (control bit 16) is set, in which case non-valid stays clear.
- R7: Writing 1 to status bit 0 clears the violation flag only when non-valid is set, all enables are zero and all detect flags are clear. Otherwise the write is ignored.
- R8: Writing 1 to status bit 1 clears non-valid only when the violation flag is clear.
- R9: While the unit is in failure without non-valid, all status writes are ignored.
- R10: `viol_irq_o` is high exactly when the violation flag and the interrupt enable (select 3, bit 0) are both set.
- R11: When an event and a clear of the same detect flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| batt_rst_n | input | 1 | Battery power-on reset, asynchronous, active low |
| sys_rst | input | 1 | System power-on reset, synchronous, active high |
| evt_i | input | 10 | Tamper event pulses, in the same order as the enable bits |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 enables, 1 control locks, 2 status clear, 3 interrupt enable |
| wr_data | input | 32 | Write data |
| status_o | output | 32 | Status word: detect flags, write error, non-valid, violation |
| tamper_en_o | output | 10 | Tamper enable bits |
| ctrl_o | output | 32 | Control word with lock bits 30, 29 and 16 |
| irq_en_o | output | 1 | Violation interrupt enable |
| viol_irq_o | output | 1 | Violation interrupt |
| freeze_o | output | 1 | Counter freeze, high in the failure condition |

## Verification
The hardest situation to reach is the recoverable combination of failure and non-valid. Reaching it takes four steps: leave the battery-reset state, enable a source, fire it, and then apply a system reset with the failure hard lock clear. The directed part walks this path. It then tries each clearing step out of order, and each one must be refused until its preconditions hold. The random part keeps event pulses sparse and lock writes rare, so that long runs of random status writes sometimes complete a recovery without help. Every cycle is compared against a bench model of the flags.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int NUM_EVT   = 10;
  localparam int WORD_W    = 32;
  localparam int BIT_VIOL  = 0;
  localparam int BIT_NVAL  = 1;
  localparam int BIT_WERR  = 7;
  localparam int BIT_FHARD = 16;
  localparam int BIT_SOFT  = 29;
  localparam int BIT_HARD  = 30;
  localparam int BIT_IRQEN = 0;

  typedef enum logic [1:0] {
    SEL_TCFG = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_IRQ  = 2'd3
  } wsel_e;

  // position of event i's detect flag inside the status word
  function automatic int det_pos(input int i);
    if (i < 8) return 16 + i;
    return i - 6;
  endfunction

  function automatic logic [WORD_W-1:0] det_to_word(input logic [NUM_EVT-1:0] det);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int i = 0; i < NUM_EVT; i++) w[det_pos(i)] = det[i];
    return w;
  endfunction

  function automatic logic [NUM_EVT-1:0] word_to_det(input logic [WORD_W-1:0] w);
    logic [NUM_EVT-1:0] m;
    for (int i = 0; i < NUM_EVT; i++) m[i] = w[det_pos(i)];
    return m;
  endfunction
endpackage

// File: rtl/tsc_lock.sv
module tsc_lock (
  input  logic clk,
  input  logic batt_rst_n,
  input  logic sys_rst,
  input  logic set_hard,
  input  logic set_soft,
  input  logic set_fhard,
  output logic hard_lk,
  output logic soft_lk,
  output logic fail_hlk
);
  always_ff @(posedge clk or negedge batt_rst_n) begin
    if (!batt_rst_n) begin
      hard_lk  <= 1'b0;
      soft_lk  <= 1'b0;
      fail_hlk <= 1'b0;
    end else begin
      hard_lk  <= hard_lk | set_hard;
      fail_hlk <= fail_hlk | set_fhard;
      soft_lk  <= sys_rst ? 1'b0 : (soft_lk | set_soft);
    end
  end

  AST_HARD_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!batt_rst_n)
    hard_lk |=> hard_lk); // R5
  AST_FAIL_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!batt_rst_n)
    fail_hlk |=> fail_hlk); // R5
  AST_SOFT_LOCK_DROPS: assert property (@(posedge clk) disable iff (!batt_rst_n)
    sys_rst |=> !soft_lk); // R5
endmodule

// File: rtl/tsc_detect.sv
module tsc_detect #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         batt_rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] det
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge batt_rst_n) begin
      if (!batt_rst_n) det[i] <= 1'b0;
      else             det[i] <= evt[i] | (det[i] & ~clr[i]);
    end

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!batt_rst_n)
      evt[i] |=> det[i]); // R11
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!batt_rst_n)
      (det[i] && !clr[i]) |=> det[i]); // R2
  end
endmodule

// File: rtl/tsc_state.sv
module tsc_state (
  input  logic clk,
  input  logic batt_rst_n,
  input  logic sys_rst,
  input  logic trig,
  input  logic clr_viol_wr,
  input  logic clr_nval_wr,
  input  logic cause_clean,
  input  logic fail_hlk,
  output logic nval,
  output logic viol,
  output logic fail_only
);
  logic viol_clear;
  logic nval_clear;
  logic nval_set;

  assign viol_clear = clr_viol_wr & nval & cause_clean;
  assign nval_clear = clr_nval_wr & ~viol;
  assign nval_set   = sys_rst & viol & ~fail_hlk;
  assign fail_only  = viol & ~nval;

  always_ff @(posedge clk or negedge batt_rst_n) begin
    if (!batt_rst_n) begin
      nval <= 1'b1;
      viol <= 1'b0;
    end else begin
      viol <= trig | (viol & ~viol_clear);
      nval <= nval_set | (nval & ~nval_clear);
    end
  end

  AST_VIOL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!batt_rst_n)
    $rose(viol) |-> $past(trig)); // R3
  AST_VIOL_EXIT_NVAL: assert property (@(posedge clk) disable iff (!batt_rst_n)
    $fell(viol) |-> $past(nval && cause_clean)); // R7
  AST_NVAL_EXIT_SAFE: assert property (@(posedge clk) disable iff (!batt_rst_n)
    $fell(nval) |-> $past(!viol)); // R8
  AST_FHL_BLOCKS_NVAL: assert property (@(posedge clk) disable iff (!batt_rst_n)
    (fail_hlk && !nval) |=> !nval); // R6
endmodule

// File: rtl/tamper_sec_ctrl.sv
module tamper_sec_ctrl
  import tsc_pkg::*;
(
  input  logic                clk,
  input  logic                batt_rst_n,
  input  logic                sys_rst,
  input  logic [NUM_EVT-1:0]  evt_i,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [WORD_W-1:0]   wr_data,
  output logic [WORD_W-1:0]   status_o,
  output logic [NUM_EVT-1:0]  tamper_en_o,
  output logic [WORD_W-1:0]   ctrl_o,
  output logic                irq_en_o,
  output logic                viol_irq_o,
  output logic                freeze_o
);
  wsel_e              sel;
  logic               hard_lk, soft_lk, fail_hlk;
  logic               nval, viol, fail_only;
  logic               cfg_hit, cfg_ok, cfg_bad, ctl_wr, stat_wr;
  logic               trig, cause_clean, werr;
  logic [NUM_EVT-1:0] det, det_clr;

  assign sel         = wsel_e'(wr_sel);
  assign cfg_hit     = wr_en && (sel == SEL_TCFG);
  assign cfg_ok      = cfg_hit && !(soft_lk || hard_lk || fail_only);
  assign cfg_bad     = cfg_hit && !cfg_ok;
  assign ctl_wr      = wr_en && (sel == SEL_CTRL);
  assign stat_wr     = wr_en && (sel == SEL_STAT) && !fail_only;
  assign det_clr     = stat_wr ? word_to_det(wr_data) : '0;
  assign trig        = |(evt_i & tamper_en_o);
  assign cause_clean = (tamper_en_o == '0) && (det == '0);

  tsc_lock u_lock (
    .clk       (clk),
    .batt_rst_n(batt_rst_n),
    .sys_rst   (sys_rst),
    .set_hard  (ctl_wr & wr_data[BIT_HARD]),
    .set_soft  (ctl_wr & wr_data[BIT_SOFT]),
    .set_fhard (ctl_wr & wr_data[BIT_FHARD]),
    .hard_lk   (hard_lk),
    .soft_lk   (soft_lk),
    .fail_hlk  (fail_hlk)
  );

  tsc_detect #(.N(NUM_EVT)) u_detect (
    .clk       (clk),
    .batt_rst_n(batt_rst_n),
    .evt       (evt_i),
    .clr       (det_clr),
    .det       (det)
  );

  tsc_state u_state (
    .clk        (clk),
    .batt_rst_n (batt_rst_n),
    .sys_rst    (sys_rst),
    .trig       (trig),
    .clr_viol_wr(stat_wr & wr_data[BIT_VIOL]),
    .clr_nval_wr(stat_wr & wr_data[BIT_NVAL]),
    .cause_clean(cause_clean),
    .fail_hlk   (fail_hlk),
    .nval       (nval),
    .viol       (viol),
    .fail_only  (fail_only)
  );

  always_ff @(posedge clk or negedge batt_rst_n) begin
    if (!batt_rst_n) begin
      tamper_en_o <= '0;
      werr        <= 1'b0;
      irq_en_o    <= 1'b0;
    end else begin
      if (cfg_ok) tamper_en_o <= wr_data[NUM_EVT-1:0];
      werr <= cfg_bad | (werr & ~(stat_wr & wr_data[BIT_WERR]));
      if (wr_en && (sel == SEL_IRQ)) irq_en_o <= wr_data[BIT_IRQEN];
    end
  end

  always_comb begin
    status_o           = det_to_word(det);
    status_o[BIT_WERR] = werr;
    status_o[BIT_NVAL] = nval;
    status_o[BIT_VIOL] = viol;
    ctrl_o             = '0;
    ctrl_o[BIT_HARD]   = hard_lk;
    ctrl_o[BIT_SOFT]   = soft_lk;
    ctrl_o[BIT_FHARD]  = fail_hlk;
  end

  assign viol_irq_o = viol & irq_en_o;
  assign freeze_o   = viol;

  AST_CFG_GUARD: assert property (@(posedge clk) disable iff (!batt_rst_n)
    (cfg_hit && (soft_lk || hard_lk || fail_only)) |=> ($stable(tamper_en_o) && status_o[BIT_WERR])); // R4
  AST_FAILONLY_FROZEN: assert property (@(posedge clk) disable iff (!batt_rst_n)
    (wr_en && (sel == SEL_STAT) && fail_only && (evt_i == '0)) |=> $stable(det)); // R9
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!batt_rst_n)
    (irq_en_o && freeze_o) |-> viol_irq_o); // R10
endmodule

// File: tb/tb_tamper_sec_ctrl.sv
`timescale 1ns/1ps
module tb_tamper_sec_ctrl;
  logic        clk = 1'b0;
  logic        batt_rst_n = 1'b0;
  logic        sys_rst = 1'b0;
  logic [9:0]  evt = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] status_o, ctrl_o;
  logic [9:0]  tamper_en_o;
  logic        irq_en_o, viol_irq_o, freeze_o;

  always #2.5 clk = ~clk;

  tamper_sec_ctrl dut (
    .clk(clk), .batt_rst_n(batt_rst_n), .sys_rst(sys_rst), .evt_i(evt),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .status_o(status_o),
    .tamper_en_o(tamper_en_o), .ctrl_o(ctrl_o), .irq_en_o(irq_en_o),
    .viol_irq_o(viol_irq_o), .freeze_o(freeze_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  bit       m_nvf, m_svf, m_werr, m_hl, m_sl, m_fl, m_irq;
  bit [9:0] m_det, m_en;

  function automatic int flag_bit(input int i);
    return (i < 8) ? i + 16 : i - 6;
  endfunction

  function automatic logic [31:0] exp_status();
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < 10; i++) s[flag_bit(i)] = m_det[i];
    s[7] = m_werr;
    s[1] = m_nvf;
    s[0] = m_svf;
    return s;
  endfunction

  function automatic logic [31:0] exp_ctrl();
    logic [31:0] c;
    c = '0;
    c[30] = m_hl;
    c[29] = m_sl;
    c[16] = m_fl;
    return c;
  endfunction

  task automatic chk(input string tag, input string fld, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "status", status_o, exp_status());
    chk(tag, "enables", {22'd0, tamper_en_o}, {22'd0, m_en});
    chk(tag, "ctrl", ctrl_o, exp_ctrl());
    chk(tag, "irq_en", {31'd0, irq_en_o}, {31'd0, m_irq});
    chk(tag, "viol_irq", {31'd0, viol_irq_o}, {31'd0, m_svf & m_irq});
    chk(tag, "freeze", {31'd0, freeze_o}, {31'd0, m_svf});
  endtask

  task automatic model_reset();
    m_nvf = 1; m_svf = 0; m_werr = 0; m_hl = 0; m_sl = 0; m_fl = 0; m_irq = 0;
    m_det = '0; m_en = '0;
  endtask

  task automatic model_step(input bit [9:0] ev, input bit we, input bit [1:0] sel,
                            input bit [31:0] d, input bit sr);
    bit fo, cok, cbad, sw, cw, trg, clean;
    bit [9:0] clr;
    bit n_svf, n_nvf;
    fo    = m_svf && !m_nvf;
    cok   = we && sel == 2'd0 && !(m_sl || m_hl || fo);
    cbad  = we && sel == 2'd0 && !cok;
    sw    = we && sel == 2'd2 && !fo;
    cw    = we && sel == 2'd1;
    clr   = '0;
    if (sw) for (int i = 0; i < 10; i++) clr[i] = d[flag_bit(i)];
    trg   = |(ev & m_en);
    clean = (m_en == 0) && (m_det == 0);
    n_svf = trg || (m_svf && !(sw && d[0] && m_nvf && clean));
    n_nvf = (sr && m_svf && !m_fl) || (m_nvf && !(sw && d[1] && !m_svf));
    m_det  = (m_det & ~clr) | ev;
    m_werr = cbad || (m_werr && !(sw && d[7]));
    if (cok) m_en = d[9:0];
    m_hl = m_hl || (cw && d[30]);
    m_fl = m_fl || (cw && d[16]);
    m_sl = sr ? 1'b0 : (m_sl || (cw && d[29]));
    if (we && sel == 2'd3) m_irq = d[0];
    m_svf = n_svf;
    m_nvf = n_nvf;
  endtask

  task automatic step(input string tag, input bit [9:0] ev, input bit we, input bit [1:0] sel,
                      input bit [31:0] d, input bit sr);
    @(negedge clk);
    evt = ev; wr_en = we; wr_sel = sel; wr_data = d; sys_rst = sr;
    model_step(ev, we, sel, d, sr);
    @(posedge clk);
    #1;
    compare(tag);
    evt = '0; wr_en = 0; sys_rst = 0;
  endtask

  task automatic batt(input string tag);
    @(negedge clk);
    batt_rst_n = 0;
    evt = '0; wr_en = 0; sys_rst = 0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    batt_rst_n = 1;
    #1;
    compare(tag);
  endtask

  task automatic wcfg(input string t, input bit [31:0] d); step(t, '0, 1, 2'd0, d, 0); endtask
  task automatic wctl(input string t, input bit [31:0] d); step(t, '0, 1, 2'd1, d, 0); endtask
  task automatic wst (input string t, input bit [31:0] d); step(t, '0, 1, 2'd2, d, 0); endtask
  task automatic wirq(input string t, input bit [31:0] d); step(t, '0, 1, 2'd3, d, 0); endtask
  task automatic fire(input string t, input bit [9:0] ev); step(t, ev, 0, 2'd0, '0, 0); endtask
  task automatic sysr(input string t); step(t, '0, 0, 2'd0, '0, 1); endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    model_reset();
    // R1 reset state
    batt("R1");
    chk("R1", "status literal", status_o, 32'h0000_0002);
    chk("R1", "freeze literal", {31'd0, freeze_o}, 32'd0);
    // R2 / R3 events without enable
    fire("R2 R3", 10'h001);
    chk("R2", "voltage flag", status_o, 32'h0001_0002);
    fire("R2", 10'h200);
    chk("R2", "monotonic flag", status_o, 32'h0001_000A);
    wst("R2", 32'h0001_0008);
    chk("R2", "cleared", status_o, 32'h0000_0002);
    wst("R8", 32'h2);
    chk("R8", "valid", status_o, 32'h0);
    // R3 / R10 enabled event
    wirq("R10", 32'h1);
    chk("R10", "no irq when valid", {31'd0, viol_irq_o}, 32'd0);
    wcfg("R3", 32'h20);
    fire("R3", 10'h020);
    chk("R3", "ext A violation", status_o, 32'h0020_0001);
    chk("R10", "irq up", {31'd0, viol_irq_o}, 32'd1);
    // R4 / R9 failure-only state
    wcfg("R4", 32'h0);
    chk("R4", "write error", status_o, 32'h0020_0081);
    chk("R4", "enables kept", {22'd0, tamper_en_o}, 32'h20);
    wst("R9", 32'h0020_0083);
    chk("R9", "status frozen", status_o, 32'h0020_0081);
    // R6 failure hard lock blocks the system reset path
    wctl("R6", 32'h0001_0000);
    sysr("R6");
    chk("R6", "stays failure only", status_o, 32'h0020_0081);
    // R5 battery releases the hard locks
    batt("R5");
    chk("R5", "ctrl cleared", ctrl_o, 32'h0);
    // R6 / R7 / R8 recovery order
    wst("R8", 32'h2);
    wcfg("R6", 32'h100);
    fire("R6", 10'h100);
    chk("R6", "timer overflow violation", status_o, 32'h0000_0005);
    sysr("R6");
    chk("R6", "non-valid added", status_o, 32'h0000_0007);
    wst("R8", 32'h2);
    chk("R8", "refused in failure", status_o, 32'h0000_0007);
    wst("R7", 32'h1);
    chk("R7", "refused with enables", status_o, 32'h0000_0007);
    wcfg("R7", 32'h0);
    wst("R7", 32'h1);
    chk("R7", "refused with flag", status_o, 32'h0000_0007);
    wst("R7", 32'h4);
    wst("R7", 32'h1);
    chk("R7", "violation cleared", status_o, 32'h0000_0002);
    wst("R8", 32'h2);
    chk("R8", "valid again", status_o, 32'h0);
    // R11 event beats clear
    step("R11", 10'h080, 1, 2'd2, 32'h0080_0000, 0);
    chk("R11", "wire-mesh kept", status_o, 32'h0080_0000);
    wst("R11", 32'h0080_0000);
    // R5 / R4 lock behaviour
    wctl("R5", 32'h4000_0000);
    wctl("R5", 32'h0);
    chk("R5", "hard lock stays", ctrl_o, 32'h4000_0000);
    wcfg("R4", 32'h3FF);
    chk("R4", "hard lock blocks", {22'd0, tamper_en_o}, 32'h0);
    sysr("R5");
    chk("R5", "hard lock survives sys reset", ctrl_o, 32'h4000_0000);
    wst("R4", 32'h80);
    chk("R4", "error cleared", status_o, 32'h0);
    batt("R5");
    wctl("R5", 32'h2000_0000);
    wcfg("R4", 32'h5);
    chk("R4", "soft lock blocks", status_o, 32'h0000_0082);
    sysr("R5");
    chk("R5", "soft lock released", ctrl_o, 32'h0);
    wcfg("R4", 32'h5);
    chk("R4", "write accepted", {22'd0, tamper_en_o}, 32'h5);

    // constrained random phase
    for (int n = 0; n < 3000; n++) begin
      bit [9:0]  ev;
      bit        we, sr;
      bit [1:0]  sel;
      bit [31:0] d;
      if (n % 400 == 0) batt("R1");
      ev  = ($urandom % 100 < 12) ? (10'h1 << ($urandom % 10)) : 10'h0;
      we  = ($urandom % 3) != 0;
      sel = 2'($urandom % 4);
      case (sel)
        2'd0:    d = ($urandom % 2) ? 32'h0 : $urandom;
        2'd1:    d = ($urandom % 10 == 0) ? $urandom : 32'h0;
        default: d = $urandom;
      endcase
      sr = ($urandom % 40) == 0;
      step("R2 R3 R4 R6 R7 R8 R9 random", ev, we, sel, d, sr);
    end
    finish_run();
  end
endmodule